// File: doc/BRIEF.md
# Receive Frame Acceptance Arbiter

This block decides, once per received frame, whether the frame is kept or dropped. It combines the results of the controller's own address checks (station address, multicast hash filter, broadcast) with a reject line driven by external address-lookup logic. The reject line is active low and asynchronous to the block clock. It only counts while a window measured in received bit times after the start-of-frame delimiter is open.

A frame opens when the receiver reports the delimiter and closes when it reports end-of-frame. One clock later the block issues a single-cycle decision pulse carrying accept or reject. Promiscuous mode accepts everything. An internal hit accepts the frame regardless of the external line. With external lookup enabled and no internal hit, the frame is accepted unless a reject was seen inside the window. A run-enable input, the controller's global start bit, gates the whole block. It does not depend on the receiver or transmitter being enabled.

Top module: `rx_accept_arbiter`

## Requirements
- R1: After reset `decValid` and `decAccept` are both 0.
- R2: `frameEnd` while a frame is open (opened by `sfdSeen`, `runEn`=1) produces `decValid`=1 for exactly one cycle, on the clock after the `frameEnd` edge. A `frameEnd` with no open frame produces no pulse.
- R3: With `cfgPromisc`=1 every frame is accepted, whatever the reject line, the match flags or the frame length.
- R4: Without promiscuous mode, a frame that is not a rejected runt is accepted whatever the reject line does, if any of these internal hits is present: `matchPhys` with `cfgNoPhys`=0, `matchBcast` with `cfgNoBcast`=0, or `matchLogic` with `cfgFilterZero`=0.
- R5: With `cfgExtEn`=1, no promiscuous mode, no internal hit and no runt rejection, the frame is accepted exactly when no reject was captured inside the window.
- R6: The block counts `bitTick` pulses from the delimiter and saturates the count at 512. `extRejectN` passes through two flops, so a low applied in the cycle sampled at edge r is judged at edge r+2. It is captured only if the count at that edge lies from 2 through 511. Lows judged at any other count are ignored.
- R7: A captured reject is sticky. A one-cycle low inside the window rejects the frame even after the line returns high. The capture is cleared by the next delimiter.
- R8: With `cfgRuntOk`=0 and no promiscuous mode, a frame that ends before 512 bit ticks is rejected even when it has an internal hit. With `cfgRuntOk`=1, or with at least 512 ticks, the other rules decide.
- R9: With no promiscuous mode, no external lookup and no internal hit, the frame is rejected.
- R10: While `runEn`=0 the block opens no frame and issues no decision. Dropping `runEn` during a frame abandons that frame, and its later `frameEnd` issues no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Global start; block idle when 0 |
| bitTick | input | 1 | One pulse per received bit time |
| sfdSeen | input | 1 | Start-of-frame delimiter detected (one-cycle pulse) |
| frameEnd | input | 1 | End of received frame (one-cycle pulse) |
| matchPhys | input | 1 | Station address matched, valid at frameEnd |
| matchLogic | input | 1 | Multicast hash filter matched, valid at frameEnd |
| matchBcast | input | 1 | Broadcast destination, valid at frameEnd |
| cfgPromisc | input | 1 | Accept all frames |
| cfgExtEn | input | 1 | Honour the external reject line |
| cfgRuntOk | input | 1 | Frames shorter than 512 bit times may be accepted |
| cfgNoBcast | input | 1 | Broadcast frames do not count as a hit |
| cfgNoPhys | input | 1 | Station address match does not count as a hit |
| cfgFilterZero | input | 1 | Hash filter cleared; hash matches do not count |
| extRejectN | input | 1 | External reject, active low, asynchronous |
| decValid | output | 1 | Decision strobe, one cycle per frame |
| decAccept | output | 1 | 1 = accept, 0 = reject; meaningful with decValid |

## Verification
The state that can go wrong is the bit-time count, the synchronizer stages and the sticky reject capture. None of them is visible except through the verdict, and a fault shows up only at the next frame's decision pulse, one cycle after `frameEnd`. A window boundary that is off by one flips the verdict only for a reject timed exactly on the second or the 512th bit time, so single-cycle pulses are placed on both sides of each edge. A sticky flag that is never cleared shows up as a wrong reject on the following clean frame. A count that saturates at the wrong value shows up as a wrong runt verdict for frames ending at 511 or 512 ticks.

// File: rtl/rxacc_pkg.sv
package rxacc_pkg;
  // Strobes from the frame controller to the verdict datapath.
  typedef struct packed {
    logic clrSticky;  // delimiter accepted: start new frame
    logic inWindow;   // reject capture window open this cycle
    logic fire;       // frame closes this cycle: register verdict
    logic runt;       // frame shorter than the full window
  } rxaccStrobe_t;
endpackage

// File: rtl/rxacc_ctrl.sv
module rxacc_ctrl
  import rxacc_pkg::*;
#(
  parameter int WIN_START = 2,
  parameter int WIN_END   = 512
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         runEn,
  input  logic         bitTick,
  input  logic         sfdSeen,
  input  logic         frameEnd,
  output rxaccStrobe_t stb
);
  localparam int CNT_W = $clog2(WIN_END + 1);
  localparam logic [CNT_W-1:0] START_V = CNT_W'(WIN_START);
  localparam logic [CNT_W-1:0] END_V   = CNT_W'(WIN_END);

  logic             inFrame;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      bitCnt  <= '0;
    end else if (!runEn) begin
      inFrame <= 1'b0;
    end else if (sfdSeen) begin
      inFrame <= 1'b1;
      bitCnt  <= '0;
    end else if (inFrame) begin
      if (frameEnd) begin
        inFrame <= 1'b0;
      end else if (bitTick && (bitCnt != END_V)) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  logic active;
  assign active = runEn && inFrame && !sfdSeen;

  always_comb begin
    stb.clrSticky = runEn && sfdSeen;
    stb.inWindow  = active && !frameEnd && (bitCnt >= START_V) && (bitCnt < END_V);
    stb.fire      = active && frameEnd;
    stb.runt      = bitCnt < END_V;
  end
endmodule

// File: rtl/rxacc_datapath.sv
module rxacc_datapath
  import rxacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         extRejectN,
  input  rxaccStrobe_t stb,
  input  logic         matchPhys,
  input  logic         matchLogic,
  input  logic         matchBcast,
  input  logic         cfgPromisc,
  input  logic         cfgExtEn,
  input  logic         cfgRuntOk,
  input  logic         cfgNoBcast,
  input  logic         cfgNoPhys,
  input  logic         cfgFilterZero,
  output logic         decValid,
  output logic         decAccept
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rejSeen;
  logic                   sticky;
  logic                   hit;
  logic                   verdict;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extRejectN};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= extRejectN;
      end
    end
  endgenerate

  assign rejSeen = !syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        sticky <= 1'b0;
    else if (stb.clrSticky)           sticky <= 1'b0;
    else if (stb.inWindow && rejSeen) sticky <= 1'b1;
  end

  assign hit = (matchPhys  && !cfgNoPhys)  ||
               (matchBcast && !cfgNoBcast) ||
               (matchLogic && !cfgFilterZero);

  always_comb begin
    if (cfgPromisc)                  verdict = 1'b1;
    else if (stb.runt && !cfgRuntOk) verdict = 1'b0;
    else if (hit)                    verdict = 1'b1;
    else if (cfgExtEn)               verdict = !sticky;
    else                             verdict = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid  <= stb.fire;
      decAccept <= stb.fire && verdict;
    end
  end
endmodule

// File: rtl/rx_accept_arbiter.sv
module rx_accept_arbiter
  import rxacc_pkg::*;
#(
  parameter int WIN_START   = 2,
  parameter int WIN_END     = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic bitTick,
  input  logic sfdSeen,
  input  logic frameEnd,
  input  logic matchPhys,
  input  logic matchLogic,
  input  logic matchBcast,
  input  logic cfgPromisc,
  input  logic cfgExtEn,
  input  logic cfgRuntOk,
  input  logic cfgNoBcast,
  input  logic cfgNoPhys,
  input  logic cfgFilterZero,
  input  logic extRejectN,
  output logic decValid,
  output logic decAccept
);
  rxaccStrobe_t stb;

  rxacc_ctrl #(.WIN_START(WIN_START), .WIN_END(WIN_END)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .bitTick(bitTick),
    .sfdSeen(sfdSeen), .frameEnd(frameEnd), .stb(stb)
  );

  rxacc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extRejectN(extRejectN), .stb(stb),
    .matchPhys(matchPhys), .matchLogic(matchLogic), .matchBcast(matchBcast),
    .cfgPromisc(cfgPromisc), .cfgExtEn(cfgExtEn), .cfgRuntOk(cfgRuntOk),
    .cfgNoBcast(cfgNoBcast), .cfgNoPhys(cfgNoPhys), .cfgFilterZero(cfgFilterZero),
    .decValid(decValid), .decAccept(decAccept)
  );
endmodule

// File: rtl/rxacc_checker.sv
module rxacc_checker (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic bitTick,
  input logic sfdSeen,
  input logic frameEnd,
  input logic matchPhys,
  input logic matchLogic,
  input logic matchBcast,
  input logic cfgPromisc,
  input logic cfgExtEn,
  input logic cfgRuntOk,
  input logic cfgNoBcast,
  input logic cfgNoPhys,
  input logic cfgFilterZero,
  input logic extRejectN,
  input logic decValid,
  input logic decAccept
);
  logic hitNow;
  assign hitNow = (matchPhys && !cfgNoPhys) || (matchBcast && !cfgNoBcast) ||
                  (matchLogic && !cfgFilterZero);

  // R2: the decision strobe never lasts longer than one cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);

  // R3: promiscuous mode always accepts
  p_promisc_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(cfgPromisc)) |-> decAccept);

  // R4: an internal hit with runts allowed always accepts
  p_hit_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(hitNow && cfgRuntOk)) |-> decAccept);

  // R9: nothing to accept on
  p_no_source_reject_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(!cfgPromisc && !cfgExtEn && !hitNow)) |-> !decAccept);

  // R10: stopped block issues nothing
  p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !decValid);
endmodule

bind rx_accept_arbiter rxacc_checker u_chk (.*);

// File: tb/sim_rx_accept_arbiter.sv
`timescale 1ns/1ps
module sim_rx_accept_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b1, bitTick = 1'b0, sfdSeen = 1'b0, frameEnd = 1'b0;
  logic matchPhys = 1'b0, matchLogic = 1'b0, matchBcast = 1'b0;
  logic cfgPromisc = 1'b0, cfgExtEn = 1'b0, cfgRuntOk = 1'b1;
  logic cfgNoBcast = 1'b0, cfgNoPhys = 1'b0, cfgFilterZero = 1'b0;
  logic extRejectN = 1'b1;
  logic decValid, decAccept;

  int checks = 0, failures = 0, validCount = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_accept_arbiter u0 (.*);

  // Spec model, advanced on the same edges the design sees.
  logic mS1, mS2, mIn, mStk, expValid, expAcc;
  int   mCnt;
  string expTag;

  function automatic bit hitOf();
    return (matchPhys && !cfgNoPhys) || (matchBcast && !cfgNoBcast) ||
           (matchLogic && !cfgFilterZero);
  endfunction

  function automatic bit expDecision(bit runt, bit stk);
    if (cfgPromisc) return 1'b1;
    if (runt && !cfgRuntOk) return 1'b0;
    if (hitOf()) return 1'b1;
    if (cfgExtEn) return !stk;
    return 1'b0;
  endfunction

  function automatic string tagOf(bit runt);
    if (cfgPromisc) return "R3";
    if (runt && !cfgRuntOk) return "R8";
    if (hitOf()) return "R4";
    if (cfgExtEn) return "R5";
    return "R9";
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 1; mS2 <= 1; mIn <= 0; mStk <= 0; mCnt <= 0;
      expValid <= 0; expAcc <= 0; expTag <= "R1";
    end else begin
      mS2 <= mS1; mS1 <= extRejectN;
      expValid <= 0;
      if (!runEn) mIn <= 0;
      else if (sfdSeen) begin mIn <= 1; mCnt <= 0; mStk <= 0; end
      else if (mIn) begin
        if (frameEnd) begin
          expValid <= 1;
          expAcc   <= expDecision(mCnt < 512, mStk);
          expTag   <= tagOf(mCnt < 512);
          mIn      <= 0;
        end else begin
          if (bitTick && mCnt < 512) mCnt <= mCnt + 1;
          if (mCnt >= 2 && mCnt < 512 && !mS2) mStk <= 1;  // R6 window
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model (R2 and the verdict rules)
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (decValid) validCount++;
      if (expValid || decValid) begin
        check(decValid == expValid, {expTag, " R2 strobe"}, decValid, expValid);
        if (expValid) check(decAccept == expAcc, {expTag, " verdict"}, decAccept, expAcc);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 190000);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    summary();
  end

  // Runs one frame; want = -1 means the model alone decides.
  task automatic runFrame(input int nBits, input int gap, input int rejOff,
                          input int rejLen, input int stopAt, input int want,
                          input string tag);
    int ticks = 0;
    int last;
    last = nBits * gap;
    if (rejOff + rejLen > last) last = rejOff + rejLen;
    @(negedge clk);
    sfdSeen = 1;
    extRejectN = !(rejOff == 0 && rejLen > 0);
    for (int c = 1; c <= last; c++) begin
      @(negedge clk);
      sfdSeen = 0;
      bitTick = (c % gap == 0) && (ticks < nBits);
      if (bitTick) ticks++;
      extRejectN = !(rejOff >= 0 && c >= rejOff && c < rejOff + rejLen);
      if (stopAt >= 0 && c == stopAt) runEn = 0;
    end
    @(negedge clk);
    sfdSeen = 0; bitTick = 0; extRejectN = 1; frameEnd = 1;
    @(negedge clk);
    frameEnd = 0;
    if (want >= 0) begin
      check(decValid == (stopAt < 0), {tag, " strobe"}, decValid, stopAt < 0);
      if (stopAt < 0) check(decAccept == want[0], tag, decAccept, want);
    end
    repeat (2) @(negedge clk);
    runEn = 1;
  endtask

  task automatic setCfg(input bit pr, input bit ex, input bit ro, input bit nb,
                        input bit np, input bit fz, input bit mp, input bit ml,
                        input bit mb);
    cfgPromisc = pr; cfgExtEn = ex; cfgRuntOk = ro; cfgNoBcast = nb;
    cfgNoPhys = np; cfgFilterZero = fz; matchPhys = mp; matchLogic = ml;
    matchBcast = mb;
  endtask

  initial begin
    int vc;
    int seed;
    seed = $urandom(32'h5eed_0a11);
    repeat (3) @(negedge clk);
    check(decValid == 0 && decAccept == 0, "R1 reset", {decValid, decAccept}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R2: stray frameEnd
    vc = validCount;
    frameEnd = 1; @(negedge clk); frameEnd = 0; repeat (2) @(negedge clk);
    check(validCount == vc, "R2 stray end", validCount - vc, 0);

    // R3: promiscuous overrides reject and runt
    setCfg(1,1,0,0,0,0,0,0,0);
    runFrame(600, 1, 1, 520, -1, 1, "R3 reject ignored");
    runFrame(40, 1, -1, 0, -1, 1, "R3 runt accepted");

    // R4: internal hit overrides reject; masked hits do not count
    setCfg(0,1,1,0,0,0,1,0,0);
    runFrame(600, 1, 5, 10, -1, 1, "R4 phys hit");
    setCfg(0,1,1,1,0,0,0,0,1);
    runFrame(600, 1, 5, 10, -1, 0, "R4 bcast masked");
    setCfg(0,1,1,0,0,1,0,1,0);
    runFrame(600, 1, 5, 10, -1, 0, "R4 hash masked");
    setCfg(0,1,1,0,0,0,0,1,0);
    runFrame(600, 2, 5, 10, -1, 1, "R4 hash hit");

    // R5/R6: window edges, ticks every cycle
    setCfg(0,1,1,0,0,0,0,0,0);
    runFrame(600, 1, -1, 0, -1, 1, "R5 no reject");
    runFrame(600, 1, 0, 1, -1, 1, "R6 count 1 ignored");
    runFrame(600, 1, 1, 1, -1, 0, "R6 count 2 captured");
    runFrame(600, 1, 510, 1, -1, 0, "R6 count 511 captured");
    runFrame(600, 1, 511, 1, -1, 1, "R6 count 512 ignored");

    // R7: sticky then cleared
    runFrame(600, 1, 200, 1, -1, 0, "R7 short pulse sticks");
    runFrame(600, 1, -1, 0, -1, 1, "R7 cleared next frame");

    // R8: runt rule
    setCfg(0,0,0,0,0,0,1,0,0);
    runFrame(100, 1, -1, 0, -1, 0, "R8 runt rejected");
    runFrame(511, 1, -1, 0, -1, 0, "R8 511 ticks runt");
    runFrame(512, 1, -1, 0, -1, 1, "R8 512 ticks full");
    cfgRuntOk = 1;
    runFrame(100, 1, -1, 0, -1, 1, "R8 runt allowed");

    // R9
    setCfg(0,0,1,0,0,0,0,0,0);
    runFrame(600, 1, -1, 0, -1, 0, "R9 nothing to accept");

    // R10
    setCfg(1,0,1,0,0,0,0,0,0);
    vc = validCount;
    runEn = 0;
    runFrame(50, 1, -1, 0, 0, -1, "R10 stopped");
    check(validCount == vc, "R10 stopped no strobe", validCount - vc, 0);
    vc = validCount;
    runFrame(50, 1, -1, 0, 20, -1, "R10 dropped mid frame");
    check(validCount == vc, "R10 abandoned frame", validCount - vc, 0);

    // Random frames checked by the model
    for (int f = 0; f < 100; f++) begin
      int nb, gp, ro, rl;
      setCfg(($urandom % 4) == 0, $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
             ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
             ($urandom % 4) == 0, ($urandom % 4) == 0);
      nb = ($urandom % 2) ? 10 + $urandom % 500 : 505 + $urandom % 100;
      gp = 1 + $urandom % 2;
      ro = ($urandom % 3 == 0) ? -1 : int'($urandom % (nb * gp + 4));
      rl = 1 + $urandom % 4;
      runFrame(nb, gp, ro, rl, -1, -1, "random");
    end
    summary();
  end
endmodule